// File: doc/BRIEF.md
# GPIO Output Bank with Atomic Write Aliases

This block holds the output levels and output enables for two banks of general-purpose pins and returns synchronized input levels for the same pins. A 32-bit register port with word addresses gives software four writable registers: output and enable for the low bank, and output and enable for the high bank. Each of these four registers also has three write-only aliases. A word written to an alias sets, clears or inverts only the bits that are 1 in that word, so single pins change without a read-modify-write sequence. Two masters that share the bank therefore cannot overwrite each other's changes.

The low bank is `LO_W` pins wide. The high bank has a fixed layout: 16 general pins in bits 15:0, USB D+ in bit 24, USB D- in bit 25, the flash clock in bit 26, the flash chip select in bit 27 and four flash data lines in bits 31:28. Bits 23:16 of the high bank do not exist. An enable bit of 1 makes its pin an output, and an output bit of 1 drives the pin high.

Addresses are five bits. Bit 0 selects the bank (0 low, 1 high). Bits 4:1 select the function: 0 input, 1 output, 2 output-set, 3 output-clear, 4 output-toggle, 5 enable, 6 enable-set, 7 enable-clear, 8 enable-toggle. Function codes 9 to 15 are unused.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset the output and enable registers of both banks are zero. All pin outputs and pin enables are low.
- R2: A write to function 1 or 5 replaces the whole output or enable register of the selected bank. The new value is on the pins right after the clock edge that accepts the write.
- R3: A write to function 2 or 6 ORs the written word into the output or enable register of the selected bank.
- R4: A write to function 3 or 7 ANDs the inverse of the written word into the output or enable register of the selected bank.
- R5: A write to function 4 or 8 XORs the written word into the output or enable register of the selected bank.
- R6: An aliased write changes the register on the same edge that accepts it. A read of the register in the write cycle returns the value from before the write.
- R7: In the high bank, bits 23:16 of the output and enable registers ignore writes, read as zero and drive zero on the pins. The same bits of the high input read as zero.
- R8: A read of function 0 returns the pin input levels of the selected bank after two clock edges of synchronization. The low bank is zero-extended to 32 bits. A change on an input pin is not visible after one edge and is visible after two.
- R9: Reads of the alias functions (2, 3, 4, 6, 7, 8) and of unused function codes return zero and change no register.
- R10: Writes to function 0 and to unused function codes leave every output and enable register unchanged.
- R11: An alias write to the enable register leaves the output register of the same bank unchanged, and an alias write to the output register leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe; one write is accepted per cycle it is high |
| bus_addr | input | 5 | Word address: bank in bit 0, function in bits 4:1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lo_pin_in | input | LO_W | Low bank input levels from the pads |
| lo_pin_out | output | LO_W | Low bank output levels |
| lo_pin_oe | output | LO_W | Low bank output enables |
| hi_pin_in | input | 32 | High bank input levels |
| hi_pin_out | output | 32 | High bank output levels |
| hi_pin_oe | output | 32 | High bank output enables |

## Verification
Two things can fall in the same cycle. An alias write can land on a bank's output register in the cycle when that bank's input pins change, and an alias write can land on a register in the cycle when software reads the same register. The bench provokes the first case by driving a set-alias write and a new input level on the same falling edge. It then checks that the output pins change after one edge, while the input readback still shows the old level after that edge and shows the new level only after the second. For the second case it reads the register before the accepting edge and expects the pre-write value, then reads it after the edge and expects the updated value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int FN_W     = ADDR_W - 1;
    localparam int NUM_REGS = 4;

    // register slots: bit 0 = bank, bit 1 = enable (1) or output (0)
    localparam int SLOT_LO_OUT = 0;
    localparam int SLOT_HI_OUT = 1;
    localparam int SLOT_LO_OE  = 2;
    localparam int SLOT_HI_OE  = 3;

    // function codes in address bits 4:1
    localparam logic [FN_W-1:0] FN_IN      = 4'd0;
    localparam logic [FN_W-1:0] FN_OUT     = 4'd1;
    localparam logic [FN_W-1:0] FN_OUT_SET = 4'd2;
    localparam logic [FN_W-1:0] FN_OUT_CLR = 4'd3;
    localparam logic [FN_W-1:0] FN_OUT_XOR = 4'd4;
    localparam logic [FN_W-1:0] FN_OE      = 4'd5;
    localparam logic [FN_W-1:0] FN_OE_SET  = 4'd6;
    localparam logic [FN_W-1:0] FN_OE_CLR  = 4'd7;
    localparam logic [FN_W-1:0] FN_OE_XOR  = 4'd8;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_XOR  = 3'd4
    } alias_op_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output alias_op_e         ops [NUM_REGS]
);

    logic [FN_W-1:0] fn;
    logic            bank;
    alias_op_e       op_sel;
    logic            to_oe;

    assign fn   = addr[ADDR_W-1:1];
    assign bank = addr[0];

    always_comb begin
        op_sel = OP_NONE;
        to_oe  = 1'b0;
        unique case (fn)
            FN_OUT:     op_sel = OP_LOAD;
            FN_OUT_SET: op_sel = OP_SET;
            FN_OUT_CLR: op_sel = OP_CLR;
            FN_OUT_XOR: op_sel = OP_XOR;
            FN_OE:      begin op_sel = OP_LOAD; to_oe = 1'b1; end
            FN_OE_SET:  begin op_sel = OP_SET;  to_oe = 1'b1; end
            FN_OE_CLR:  begin op_sel = OP_CLR;  to_oe = 1'b1; end
            FN_OE_XOR:  begin op_sel = OP_XOR;  to_oe = 1'b1; end
            default:    op_sel = OP_NONE;
        endcase
    end

    always_comb begin
        for (int s = 0; s < NUM_REGS; s++) begin
            ops[s] = OP_NONE;
            if (wr && (s[0] == bank) && (s[1] == to_oe)) begin
                ops[s] = op_sel;
            end
        end
    end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  alias_op_e         op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] val_d;
    logic [DATA_W-1:0] val_q;

    always_comb begin
        val_d = val_q;
        unique case (op)
            OP_LOAD: val_d = wdata;
            OP_SET:  val_d = val_q | wdata;
            OP_CLR:  val_d = val_q & ~wdata;
            OP_XOR:  val_d = val_q ^ wdata;
            default: val_d = val_q;
        endcase
        val_d = val_d & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] level
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d;
    sync_t st_q;

    always_comb begin
        st_d.meta   = pin;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.stable;

endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
    import gpio_bank_pkg::*;
#(
    parameter int                LO_W    = 32,
    parameter logic [DATA_W-1:0] HI_MASK = 32'hFF00_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LO_W-1:0]   lo_pin_in,
    output logic [LO_W-1:0]   lo_pin_out,
    output logic [LO_W-1:0]   lo_pin_oe,
    input  logic [DATA_W-1:0] hi_pin_in,
    output logic [DATA_W-1:0] hi_pin_out,
    output logic [DATA_W-1:0] hi_pin_oe
);

    localparam logic [DATA_W-1:0] LO_MASK = DATA_W'((64'd1 << LO_W) - 64'd1);

    alias_op_e         ops   [NUM_REGS];
    logic [DATA_W-1:0] reg_q [NUM_REGS];
    logic [LO_W-1:0]   lo_level;
    logic [DATA_W-1:0] hi_level;

    gpio_addr_dec u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .ops  (ops)
    );

    for (genvar s = 0; s < NUM_REGS; s++) begin : g_reg
        localparam logic [DATA_W-1:0] SLOT_MASK = (s % 2 == 1) ? HI_MASK : LO_MASK;
        gpio_alias_reg #(
            .MASK (SLOT_MASK)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (ops[s]),
            .wdata (bus_wdata),
            .q     (reg_q[s])
        );
    end

    gpio_in_sync #(.W(LO_W)) u_lo_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (lo_pin_in),
        .level (lo_level)
    );

    gpio_in_sync #(.W(DATA_W)) u_hi_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (hi_pin_in),
        .level (hi_level)
    );

    assign lo_pin_out = reg_q[SLOT_LO_OUT][LO_W-1:0];
    assign lo_pin_oe  = reg_q[SLOT_LO_OE][LO_W-1:0];
    assign hi_pin_out = reg_q[SLOT_HI_OUT];
    assign hi_pin_oe  = reg_q[SLOT_HI_OE];

    // read path: pure function of address and state, no side effects
    logic [FN_W-1:0] rd_fn;
    logic            rd_bank;

    assign rd_fn   = bus_addr[ADDR_W-1:1];
    assign rd_bank = bus_addr[0];

    always_comb begin
        bus_rdata = '0;
        unique case (rd_fn)
            FN_IN:   bus_rdata = rd_bank ? (hi_level & HI_MASK) : DATA_W'(lo_level);
            FN_OUT:  bus_rdata = rd_bank ? reg_q[SLOT_HI_OUT] : reg_q[SLOT_LO_OUT];
            FN_OE:   bus_rdata = rd_bank ? reg_q[SLOT_HI_OE]  : reg_q[SLOT_LO_OE];
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int                LO_W    = 32,
    parameter logic [DATA_W-1:0] HI_MASK = 32'hFF00_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LO_W-1:0]   lo_pin_in,
    input logic [LO_W-1:0]   lo_pin_out,
    input logic [LO_W-1:0]   lo_pin_oe,
    input logic [DATA_W-1:0] hi_pin_out,
    input logic [DATA_W-1:0] hi_pin_oe
);

    localparam logic [ADDR_W-1:0] A_LO_OUT     = {FN_OUT, 1'b0};
    localparam logic [ADDR_W-1:0] A_LO_OUT_SET = {FN_OUT_SET, 1'b0};
    localparam logic [ADDR_W-1:0] A_LO_OUT_CLR = {FN_OUT_CLR, 1'b0};
    localparam logic [ADDR_W-1:0] A_LO_OUT_XOR = {FN_OUT_XOR, 1'b0};
    localparam logic [ADDR_W-1:0] A_LO_OE_SET  = {FN_OE_SET, 1'b0};
    localparam logic [ADDR_W-1:0] A_LO_IN      = {FN_IN, 1'b0};

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        (since_rst == 2'd0) |-> (lo_pin_out == '0 && lo_pin_oe == '0 && hi_pin_out == '0 && hi_pin_oe == '0));

    // R2
    load_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_OUT) |=> (lo_pin_out == $past(bus_wdata[LO_W-1:0])));

    // R3
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_OUT_SET) |=> (lo_pin_out == ($past(lo_pin_out) | $past(bus_wdata[LO_W-1:0]))));

    // R4
    clr_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_OUT_CLR) |=> (lo_pin_out == ($past(lo_pin_out) & ~$past(bus_wdata[LO_W-1:0]))));

    // R5
    xor_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_OUT_XOR) |=> (lo_pin_out == ($past(lo_pin_out) ^ $past(bus_wdata[LO_W-1:0]))));

    // R7
    hi_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_pin_out & ~HI_MASK) == '0) && ((hi_pin_oe & ~HI_MASK) == '0));

    // R8
    in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && bus_addr == A_LO_IN) |-> (bus_rdata == DATA_W'($past(lo_pin_in, 2))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(lo_pin_out) && $stable(lo_pin_oe) && $stable(hi_pin_out) && $stable(hi_pin_oe)));

    // R11
    oe_alias_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO_OE_SET) |=> $stable(lo_pin_out));

endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(
    .LO_W    (LO_W),
    .HI_MASK (HI_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .lo_pin_in  (lo_pin_in),
    .lo_pin_out (lo_pin_out),
    .lo_pin_oe  (lo_pin_oe),
    .hi_pin_out (hi_pin_out),
    .hi_pin_oe  (hi_pin_oe)
);

// File: tb/sim_gpio_alias_bank.sv
`timescale 1ns/1ps
module sim_gpio_alias_bank;

    localparam int          LO_W = 32;
    localparam logic [31:0] HMSK = 32'hFF00_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] lo_pin_in = '0;
    logic [31:0] lo_pin_out;
    logic [31:0] lo_pin_oe;
    logic [31:0] hi_pin_in = '0;
    logic [31:0] hi_pin_out;
    logic [31:0] hi_pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_alias_bank #(.LO_W(LO_W), .HI_MASK(HMSK)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .lo_pin_in  (lo_pin_in),
        .lo_pin_out (lo_pin_out),
        .lo_pin_oe  (lo_pin_oe),
        .hi_pin_in  (hi_pin_in),
        .hi_pin_out (hi_pin_out),
        .hi_pin_oe  (hi_pin_oe)
    );

    // address = {function[3:0], bank}
    function automatic logic [4:0] adr(input int fn, input bit hi);
        return {4'(fn), hi};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 lo_out", lo_pin_out, 0);
        chk("R1 lo_oe", lo_pin_oe, 0);
        chk("R1 hi_out", hi_pin_out, 0);
        chk("R1 hi_oe", hi_pin_oe, 0);
        rd(adr(1, 0), v); chk("R1 read lo_out", v, 0);
        rd(adr(5, 1), v); chk("R1 read hi_oe", v, 0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(adr(1, 0), 32'hA5A5_0F0F);
        chk("R2 lo_out pins", lo_pin_out, 32'hA5A5_0F0F);
        wr(adr(5, 0), 32'h1234_5678);
        chk("R2 lo_oe pins", lo_pin_oe, 32'h1234_5678);
        chk("R2 out kept", lo_pin_out, 32'hA5A5_0F0F);
        rd(adr(1, 0), v); chk("R2 read lo_out", v, 32'hA5A5_0F0F);
        wr(adr(1, 0), 32'h0000_00F0);
        chk("R2 replace", lo_pin_out, 32'h0000_00F0);
    endtask

    task automatic t_alias_out();
        wr(adr(2, 0), 32'h8000_0001);
        chk("R3 set", lo_pin_out, 32'h8000_00F1);
        wr(adr(3, 0), 32'h0000_0030);
        chk("R4 clr", lo_pin_out, 32'h8000_00C1);
        wr(adr(4, 0), 32'hFFFF_0000);
        chk("R5 xor", lo_pin_out, 32'h7FFF_00C1);
        wr(adr(4, 0), 32'h0);
        chk("R5 xor zero", lo_pin_out, 32'h7FFF_00C1);
        chk("R11 oe untouched by out aliases", lo_pin_oe, 32'h1234_5678);
    endtask

    task automatic t_alias_oe();
        wr(adr(6, 0), 32'h0000_0001);
        chk("R3 oe set", lo_pin_oe, 32'h1234_5679);
        wr(adr(7, 0), 32'h1000_0000);
        chk("R4 oe clr", lo_pin_oe, 32'h0234_5679);
        wr(adr(8, 0), 32'hF000_000F);
        chk("R5 oe xor", lo_pin_oe, 32'hF234_5676);
        chk("R11 out untouched by oe aliases", lo_pin_out, 32'h7FFF_00C1);
    endtask

    task automatic t_same_edge();
        logic [31:0] v;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = adr(2, 0); bus_wdata = 32'h0000_0F00;
        #1;
        chk("R6 pins before edge", lo_pin_out, 32'h7FFF_00C1);
        @(posedge clk);
        #1;
        chk("R6 pins after edge", lo_pin_out, 32'h7FFF_0FC1);
        @(negedge clk);
        bus_wr = 1'b0;
        // direct read of the target in the accepting cycle
        bus_wr = 1'b1; bus_addr = adr(1, 0); bus_wdata = 32'h0000_0001;
        #1;
        chk("R6 read returns old", bus_rdata, 32'h7FFF_0FC1);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(adr(1, 0), v); chk("R6 read returns new", v, 32'h0000_0001);
    endtask

    task automatic t_hi_bank();
        logic [31:0] v;
        wr(adr(1, 1), 32'hFFFF_FFFF);
        chk("R7 hi out masked", hi_pin_out, 32'hFF00_FFFF);
        rd(adr(1, 1), v); chk("R7 hi read masked", v, 32'hFF00_FFFF);
        wr(adr(6, 1), 32'h00FF_0000);
        chk("R7 hi oe gap ignored", hi_pin_oe, 32'h0);
        wr(adr(8, 1), 32'h0F0F_0001);
        chk("R7 hi oe xor", hi_pin_oe, 32'h0F00_0001);
        wr(adr(3, 1), 32'hF000_0000);
        chk("R4 hi clr", hi_pin_out, 32'h0F00_FFFF);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk);
        lo_pin_in = 32'hCAFE_F00D;
        hi_pin_in = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        rd(adr(0, 0), v); chk("R8 lo in not after one edge", v, 32'h0);
        @(posedge clk); #1;
        rd(adr(0, 0), v); chk("R8 lo in after two edges", v, 32'hCAFE_F00D);
        rd(adr(0, 1), v); chk("R7 hi in gap reads zero", v, 32'hFF00_FFFF);
    endtask

    task automatic t_alias_reads();
        logic [31:0] v;
        for (int f = 2; f < 16; f++) begin
            if (f != 5) begin
                rd(adr(f, 0), v); chk($sformatf("R9 read fn%0d", f), v, 0);
            end
        end
        rd(adr(1, 0), v); chk("R9 lo out intact", v, 32'h0000_0001);
        rd(adr(5, 0), v); chk("R9 lo oe intact", v, 32'hF234_5676);
    endtask

    task automatic t_dead_writes();
        wr(adr(0, 0), 32'hFFFF_FFFF);
        wr(adr(0, 1), 32'hFFFF_FFFF);
        wr(adr(12, 0), 32'hFFFF_FFFF);
        wr(adr(15, 1), 32'hFFFF_FFFF);
        chk("R10 lo out", lo_pin_out, 32'h0000_0001);
        chk("R10 lo oe", lo_pin_oe, 32'hF234_5676);
        chk("R10 hi out", hi_pin_out, 32'h0F00_FFFF);
        chk("R10 hi oe", hi_pin_oe, 32'h0F00_0001);
    endtask

    task automatic t_concurrent();
        logic [31:0] v;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = adr(2, 0); bus_wdata = 32'h0000_0100;
        lo_pin_in = 32'h0000_0055;
        @(posedge clk); #1;
        chk("R3 set with input change", lo_pin_out, 32'h0000_0101);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(adr(0, 0), v); chk("R8 input still old", v, 32'hCAFE_F00D);
        @(posedge clk); #1;
        rd(adr(0, 0), v); chk("R8 input new", v, 32'h0000_0055);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_alias_out();
        t_alias_oe();
        t_same_edge();
        t_hi_bank();
        t_input();
        t_alias_reads();
        t_dead_writes();
        t_concurrent();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule